// File: doc/BRIEF.md
# Correlating Two-Level Branch Predictor

This block predicts whether a conditional branch is taken. Its state is a table of saturating counters plus a global history register. The history register holds the outcomes of the most recently resolved branches. Each table row is picked by low-order bits of the branch address. Each row holds one counter for every possible history value. The current history picks which counter of the row gives the prediction. Because of this, one branch's prediction can depend on what earlier, unrelated branches did.

The block has two ports. On the lookup side, the fetch stage presents a PC and gets back a taken/not-taken bit in the same cycle. It also gets the history value that was used, which it carries along with the branch. On the training side, the resolved branch comes back with three things: its PC, its real outcome, and the history captured at lookup time. Only the counter selected by that address and that history is trained. The real outcome is then shifted into the global history.

The parameters are the history length (HIST_BITS), the counter width (CTR_BITS), the row count (ROWS, a power of two), the PC width and the number of alignment bits. The defaults give two history bits, four 2-bit counters per row and 1024 rows. With HIST_BITS = 0 the block becomes a plain per-address table of 2-bit counters. With CTR_BITS = 1 each entry is a single bit that is overwritten by the last outcome.

Top module: `corr_bpred`

## Requirements
- R1: After a synchronous reset (rst_n low at a rising edge), the history reads zero and every counter holds the weakly-not-taken value 2^(CTR_BITS-1)-1 (binary 01 for 2-bit counters). Every lookup then predicts not taken.
- R2: The prediction is the most significant bit of the selected counter. For 2-bit counters, 10 and 11 predict taken and 00 and 01 predict not taken. The lookup is combinational from pred_pc and the current history.
- R3: A trained counter moves up by one on a taken outcome (upd_taken = 1) and down by one on a not-taken outcome. It stays at its maximum and at zero instead of wrapping.
- R4: On every cycle with upd_valid high, the history shifts left by one position and upd_taken enters bit 0 (1 = taken). The history is visible on pred_hist.
- R5: The row is PC bits [ALIGN_BITS+log2(ROWS)-1 : ALIGN_BITS]. With the defaults these are bits [11:2]. PCs that differ only in bits [1:0] or only above bit 11 share a row. PCs whose bits [11:2] differ use separate counters.
- R6: Within the row, the counter is column number upd_hist when training and column number pred_hist when looking up. A training event changes only that one counter. The other counters in the row and all other rows keep their values.
- R7: A training event is written at the rising edge that sees upd_valid high. A lookup of the same counter in that same cycle returns the old prediction. A lookup in the next cycle returns the new one.
- R8: While upd_valid is low, upd_pc, upd_taken and upd_hist have no effect. The history and every prediction stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| pred_pc | input | PC_W | Fetch address to predict |
| pred_taken | output | 1 | Prediction for pred_pc, 1 = taken |
| pred_hist | output | max(HIST_BITS,1) | Global history used by the current lookup |
| upd_valid | input | 1 | A resolved branch is presented this cycle |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_taken | input | 1 | Actual outcome, 1 = taken |
| upd_hist | input | max(HIST_BITS,1) | History captured when that branch was predicted |

## Verification
A lookup answers in the same cycle, so each one is checked one nanosecond after pred_pc is driven at a falling edge, before the next rising edge. A training event takes effect one rising edge after it is presented, and so does the history shift. The bench therefore checks each update twice. It first checks the old prediction in the presenting cycle, then the new prediction and the new pred_hist at the following falling edge. The expected values come from a counter model held in the bench. To reach a specific history column, the bench first drives the needed outcomes through a scratch address.

// File: rtl/corr_bpred_pkg.sv
// Package: corr_bpred_pkg
// Shared types and small helpers for the correlating predictor.
// Assumes nothing beyond IEEE 1800-2017 elaboration rules.
package corr_bpred_pkg;

    // Direction of a resolved branch.
    typedef enum logic {
        DIR_NOT_TAKEN = 1'b0,
        DIR_TAKEN     = 1'b1
    } dir_e;

    // Width helper that keeps zero-sized parameters at one bit.
    function automatic int unsigned min_one(input int unsigned w);
        return (w > 0) ? w : 1;
    endfunction

endpackage

// File: rtl/corr_bpred_ctr_step.sv
// Module: corr_bpred_ctr_step
// Next value of one saturating counter for a given outcome.
// Assumes CTR_BITS >= 1; for CTR_BITS = 1 the result equals the outcome.
module corr_bpred_ctr_step #(
    parameter int unsigned CTR_BITS = 2
) (
    input  logic [CTR_BITS-1:0] cur,
    input  logic                up,
    output logic [CTR_BITS-1:0] nxt
);

    localparam logic [CTR_BITS-1:0] CTR_MAX = '1;
    localparam logic [CTR_BITS-1:0] CTR_MIN = '0;

    // Saturating increment or decrement.
    always_comb begin
        if (up) begin
            nxt = (cur == CTR_MAX) ? cur : cur + CTR_BITS'(1);
        end else begin
            nxt = (cur == CTR_MIN) ? cur : cur - CTR_BITS'(1);
        end
    end

endmodule

// File: rtl/corr_bpred_ghist.sv
// Module: corr_bpred_ghist
// Global outcome history shift register.
// Assumes one resolved branch per cycle at most; with HIST_BITS = 0 the
// output is a constant zero bit.
module corr_bpred_ghist #(
    parameter int unsigned HIST_BITS = 2,
    localparam int unsigned HW = corr_bpred_pkg::min_one(HIST_BITS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          shift_en,
    input  logic          taken_in,
    output logic [HW-1:0] hist_o
);

    generate
        if (HIST_BITS == 0) begin : g_none
            logic inputs_unused;
            assign inputs_unused = ^{clk, rst_n, shift_en, taken_in};
            assign hist_o = '0;
        end else begin : g_shift
            logic [HW-1:0] hist_r;

            // Shift the resolved outcome into the low bit.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    hist_r <= '0;
                end else if (shift_en) begin
                    hist_r <= HW'({hist_r, taken_in});
                end
            end

            assign hist_o = hist_r;
        end
    endgenerate

endmodule

// File: rtl/corr_bpred_table.sv
// Module: corr_bpred_table
// Counter storage: ROWS rows, each packing COLS counters of CTR_BITS.
// One combinational read port and one clocked read-modify-write port.
// Assumes ROWS is a power of two; a same-cycle read sees the old value.
module corr_bpred_table #(
    parameter int unsigned ROWS     = 1024,
    parameter int unsigned COLS     = 4,
    parameter int unsigned CTR_BITS = 2,
    localparam int unsigned IDX_BITS = $clog2(ROWS),
    localparam int unsigned COL_BITS = (COLS > 1) ? $clog2(COLS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [IDX_BITS-1:0] rd_row,
    input  logic [COL_BITS-1:0] rd_col,
    output logic [CTR_BITS-1:0] rd_ctr,
    input  logic                wr_en,
    input  logic [IDX_BITS-1:0] wr_row,
    input  logic [COL_BITS-1:0] wr_col,
    input  logic                wr_up,
    output logic [CTR_BITS-1:0] wr_old,
    output logic [CTR_BITS-1:0] wr_new
);

    localparam int unsigned ROW_W = COLS * CTR_BITS;
    localparam logic [CTR_BITS-1:0] CTR_RST = CTR_BITS'((1 << (CTR_BITS - 1)) - 1);
    localparam logic [ROW_W-1:0] ROW_RST = {COLS{CTR_RST}};

    logic [ROW_W-1:0]    mem [ROWS];
    logic [ROW_W-1:0]    rd_line;
    logic [ROW_W-1:0]    wr_line;
    logic [ROW_W-1:0]    wr_line_nxt;
    logic [CTR_BITS-1:0] col_step [COLS];

    assign rd_line = mem[rd_row];
    assign wr_line = mem[wr_row];

    // One step unit per column; only the addressed column takes its result.
    generate
        for (genvar c = 0; c < COLS; c++) begin : g_col
            logic [CTR_BITS-1:0] cur;
            assign cur = wr_line[c*CTR_BITS +: CTR_BITS];

            corr_bpred_ctr_step #(
                .CTR_BITS(CTR_BITS)
            ) step_i (
                .cur(cur),
                .up (wr_up),
                .nxt(col_step[c])
            );

            assign wr_line_nxt[c*CTR_BITS +: CTR_BITS] =
                (wr_col == COL_BITS'(c)) ? col_step[c] : cur;
        end
    endgenerate

    assign rd_ctr = rd_line[rd_col*CTR_BITS +: CTR_BITS];
    assign wr_old = wr_line[wr_col*CTR_BITS +: CTR_BITS];
    assign wr_new = wr_line_nxt[wr_col*CTR_BITS +: CTR_BITS];

    // Clear every row on reset, otherwise write back the trained row.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < ROWS; r++) begin
                mem[r] <= ROW_RST;
            end
        end else if (wr_en) begin
            mem[wr_row] <= wr_line_nxt;
        end
    end

endmodule

// File: rtl/corr_bpred.sv
// Module: corr_bpred (top)
// Correlating (HIST_BITS, CTR_BITS) branch predictor. The PC selects a row
// and the global history selects the counter inside that row.
// Assumes: ROWS a power of two >= 2, at most one resolved branch per cycle,
// and upd_hist equal to the pred_hist seen when that branch was looked up.
module corr_bpred #(
    parameter int unsigned HIST_BITS  = 2,
    parameter int unsigned CTR_BITS   = 2,
    parameter int unsigned ROWS       = 1024,
    parameter int unsigned PC_W       = 32,
    parameter int unsigned ALIGN_BITS = 2,
    localparam int unsigned HW = corr_bpred_pkg::min_one(HIST_BITS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] pred_pc,
    output logic            pred_taken,
    output logic [HW-1:0]   pred_hist,
    input  logic            upd_valid,
    input  logic [PC_W-1:0] upd_pc,
    input  logic            upd_taken,
    input  logic [HW-1:0]   upd_hist
);

    localparam int unsigned IDX_BITS = $clog2(ROWS);
    localparam int unsigned COLS     = 1 << HIST_BITS;
    localparam int unsigned COL_BITS = (COLS > 1) ? $clog2(COLS) : 1;

    logic [IDX_BITS-1:0] rd_row;
    logic [IDX_BITS-1:0] wr_row;
    logic [COL_BITS-1:0] rd_col;
    logic [COL_BITS-1:0] wr_col;
    logic [CTR_BITS-1:0] rd_ctr;
    logic [CTR_BITS-1:0] tbl_wr_old;
    logic [CTR_BITS-1:0] tbl_wr_new;
    logic [HW-1:0]       ghist;
    logic                pc_unused;

    // Row index from the bits just above the alignment bits.
    assign rd_row    = pred_pc[ALIGN_BITS +: IDX_BITS];
    assign wr_row    = upd_pc[ALIGN_BITS +: IDX_BITS];
    assign pc_unused = ^{pred_pc, upd_pc};

    // Column select: history when correlating, fixed zero otherwise.
    generate
        if (HIST_BITS > 0) begin : g_corr
            assign rd_col = ghist;
            assign wr_col = upd_hist;
        end else begin : g_flat
            logic hist_unused;
            assign hist_unused = ^{ghist, upd_hist};
            assign rd_col = '0;
            assign wr_col = '0;
        end
    endgenerate

    corr_bpred_ghist #(
        .HIST_BITS(HIST_BITS)
    ) ghist_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .shift_en(upd_valid),
        .taken_in(upd_taken),
        .hist_o  (ghist)
    );

    corr_bpred_table #(
        .ROWS    (ROWS),
        .COLS    (COLS),
        .CTR_BITS(CTR_BITS)
    ) table_i (
        .clk   (clk),
        .rst_n (rst_n),
        .rd_row(rd_row),
        .rd_col(rd_col),
        .rd_ctr(rd_ctr),
        .wr_en (upd_valid),
        .wr_row(wr_row),
        .wr_col(wr_col),
        .wr_up (upd_taken == corr_bpred_pkg::DIR_TAKEN),
        .wr_old(tbl_wr_old),
        .wr_new(tbl_wr_new)
    );

    assign pred_taken = rd_ctr[CTR_BITS-1];
    assign pred_hist  = ghist;

endmodule

// File: rtl/corr_bpred_chk.sv
// Module: corr_bpred_chk
// Assertion checker bound into corr_bpred.
// Assumes it sees the top's ports plus the table's write-port old/new values.
module corr_bpred_chk #(
    parameter int unsigned HW       = 2,
    parameter int unsigned CTR_BITS = 2,
    parameter int unsigned PC_W     = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic [PC_W-1:0]     pred_pc,
    input logic                pred_taken,
    input logic [HW-1:0]       pred_hist,
    input logic                upd_valid,
    input logic                upd_taken,
    input logic [CTR_BITS-1:0] wr_old,
    input logic [CTR_BITS-1:0] wr_new
);

    localparam logic [CTR_BITS-1:0] MAXV = '1;

    logic armed;
    logic rst_q;

    // Arm the history-dependent checks one cycle after reset release.
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    // Remember the previous reset level.
    always_ff @(posedge clk) begin
        rst_q <= rst_n;
    end

    // R1
    reset_state_chk: assert property (@(posedge clk)
        (rst_n && rst_q === 1'b0) |-> (pred_hist == '0 && !pred_taken));

    // R4
    hist_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |=> pred_hist[0] == $past(upd_taken));

    generate
        if (HW > 1) begin : g_hist_hi
            // R4
            hist_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (armed && upd_valid) |=> pred_hist[HW-1:1] == $past(pred_hist[HW-2:0]));
        end
    endgenerate

    // R8
    idle_hist_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !upd_valid) |=> $stable(pred_hist));

    // R8
    idle_pred_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !upd_valid) |=> (!$stable(pred_pc) || $stable(pred_taken)));

    // R3
    step_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && upd_taken) |->
            ((wr_old == MAXV) ? (wr_new == MAXV) : (wr_new == wr_old + CTR_BITS'(1))));

    // R3
    step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && !upd_taken) |->
            ((wr_old == '0) ? (wr_new == '0) : (wr_new == wr_old - CTR_BITS'(1))));

endmodule

bind corr_bpred corr_bpred_chk #(
    .HW      (HW),
    .CTR_BITS(CTR_BITS),
    .PC_W    (PC_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .pred_pc   (pred_pc),
    .pred_taken(pred_taken),
    .pred_hist (pred_hist),
    .upd_valid (upd_valid),
    .upd_taken (upd_taken),
    .wr_old    (tbl_wr_old),
    .wr_new    (tbl_wr_new)
);

// File: tb/corr_bpred_tb_top.sv
// Directed bench for corr_bpred with default parameters (2 history bits,
// 2-bit counters, 1024 rows, 32-bit PC, 2 alignment bits).
module corr_bpred_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pred_pc = '0;
    logic        pred_taken;
    logic [1:0]  pred_hist;
    logic        upd_valid = 1'b0;
    logic [31:0] upd_pc = '0;
    logic        upd_taken = 1'b0;
    logic [1:0]  upd_hist = '0;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    int mdl [int];
    int mh = 0;

    localparam logic [31:0] SCR = 32'h0000_0F00;

    always #2.5 clk = ~clk;

    corr_bpred dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .pred_pc   (pred_pc),
        .pred_taken(pred_taken),
        .pred_hist (pred_hist),
        .upd_valid (upd_valid),
        .upd_pc    (upd_pc),
        .upd_taken (upd_taken),
        .upd_hist  (upd_hist)
    );

    // Record one check and report a mismatch.
    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Row per R5: PC bits [11:2].
    function automatic int row_of(input logic [31:0] pc);
        return int'(pc[11:2]);
    endfunction

    // Counter value per R1/R3 model.
    function automatic int ctr_of(input int row, input int col);
        int key = row * 4 + col;
        return mdl.exists(key) ? mdl[key] : 1;
    endfunction

    // Prediction per R2 using the model history.
    function automatic logic mdl_pred(input logic [31:0] pc);
        return ctr_of(row_of(pc), mh) >= 2;
    endfunction

    // Present one resolved branch and check before and after the edge.
    task automatic upd(input logic [31:0] pc, input bit tk, input int h, input string req);
        int key;
        int old;
        @(negedge clk);
        upd_valid = 1'b1;
        upd_pc    = pc;
        upd_taken = tk;
        upd_hist  = h[1:0];
        pred_pc   = pc;
        #1;
        chk("R7", "same-cycle lookup returns old prediction", pred_taken, mdl_pred(pc));
        @(negedge clk);
        upd_valid = 1'b0;
        key = row_of(pc) * 4 + h;
        old = ctr_of(row_of(pc), h);
        mdl[key] = tk ? ((old < 3) ? old + 1 : 3) : ((old > 0) ? old - 1 : 0);
        mh = ((mh << 1) | int'(tk)) & 3;
        #1;
        chk(req, "lookup after training", pred_taken, mdl_pred(pc));
        chk("R4", "history after shift", pred_hist, mh);
    endtask

    // Drive the global history to h through the scratch address.
    task automatic set_hist(input int h);
        upd(SCR, h[1], mh, "R4");
        upd(SCR, h[0], mh, "R4");
    endtask

    // Lookup with an explicit expected prediction.
    task automatic look(input logic [31:0] pc, input logic exp, input string req, input string what);
        @(negedge clk);
        pred_pc = pc;
        #1;
        chk(req, what, pred_taken, exp);
    endtask

    task automatic t_reset;
        chk("R1", "history after reset", pred_hist, 0);
        look(32'h0000_0000, 1'b0, "R1", "reset lookup pc 0");
        look(32'h0000_0040, 1'b0, "R1", "reset lookup pc 0x40");
        look(32'h0000_0FFC, 1'b0, "R1", "reset lookup last row");
        look(32'h1234_5678, 1'b0, "R1", "reset lookup high pc");
    endtask

    task automatic t_saturate;
        logic [31:0] a = 32'h0000_0100;
        set_hist(3);
        upd(a, 1, 3, "R2");
        upd(a, 1, 3, "R3");
        upd(a, 1, 3, "R3");
        upd(a, 0, 3, "R3");
        set_hist(3);
        look(a, 1'b1, "R3", "top saturation keeps 10 after one decrement");
        upd(a, 0, 3, "R3");
        set_hist(3);
        look(a, 1'b0, "R2", "counter 01 predicts not taken");
        set_hist(0);
        upd(a, 0, 0, "R3");
        upd(a, 0, 0, "R3");
        upd(a, 0, 0, "R3");
        upd(a, 1, 0, "R3");
        set_hist(0);
        look(a, 1'b0, "R3", "bottom saturation gives 01 after one increment");
    endtask

    task automatic t_columns;
        logic [31:0] b = 32'h0000_0200;
        upd(b, 1, 2, "R6");
        upd(b, 1, 2, "R6");
        for (int h = 0; h < 4; h++) begin
            set_hist(h);
            look(b, (h == 2), "R6", $sformatf("column %0d of trained row", h));
        end
    endtask

    task automatic t_rows;
        logic [31:0] c = 32'h0000_0300;
        set_hist(1);
        upd(c, 1, 1, "R6");
        upd(c, 1, 1, "R6");
        set_hist(1);
        look(c,                 1'b1, "R5", "trained row");
        look(c + 32'd1,         1'b1, "R5", "alignment bit 0 ignored");
        look(c + 32'd3,         1'b1, "R5", "alignment bits ignored");
        look(c + 32'h0000_1000, 1'b1, "R5", "alias above bit 11");
        look(c + 32'd4,         1'b0, "R5", "neighbour row untouched");
    endtask

    task automatic t_idle;
        logic [31:0] b = 32'h0000_0200;
        set_hist(2);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            upd_valid = 1'b0;
            upd_pc    = b;
            upd_taken = k[0];
            upd_hist  = k[1:0];
            pred_pc   = b;
            #1;
            chk("R8", "history with valid low", pred_hist, 2);
            chk("R8", "prediction with valid low", pred_taken, 1'b1);
        end
        look(b, 1'b1, "R8", "row unchanged after idle cycles");
    endtask

    task automatic t_loop;
        logic [31:0] l = 32'h0000_0400;
        for (int pass = 0; pass < 3; pass++) begin
            for (int i = 0; i < 10; i++) begin
                upd(l, (i != 9), mh, "R3");
            end
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_saturate();
        t_columns();
        t_rows();
        t_idle();
        t_loop();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule